// File: doc/BRIEF.md
# Primary Clock Loss Monitor with Failover

This block watches a primary clock against a free-running secondary reference clock and reports a complete loss of the primary. A small counter in the primary domain wraps every 2^PRI_W primary cycles. Each wrap is carried into the secondary domain, where it restarts a wider watchdog counter. If the watchdog counter ever runs through all 2^SEC_W states without a restart, the primary is considered missing. Frequency drift is not detected.

On detection the block latches a sticky fault status, raises a clock-fail level that is meant for PWM trip and non-maskable interrupt logic, and freezes its watchdog counter. While the fault is latched it overrides the clock controls it passes through: the effective source select is forced to the secondary source code, the PLL bypass request is forced on, and the PLL integer multiplier is forced to zero. Software clears the fault with a write-one-to-clear request. This also restarts both counters and hands source selection back to the normal select bits. A disable input suspends the check. All register-side inputs are treated as asynchronous to the secondary clock. All control and status pins are plain levels. There is no streaming interface.

Top module: `clk_loss_monitor`

## Requirements
- R1: Once `rst_n` is released, `fail_status` and `clock_fail` read 0 and the outputs follow their inputs: `src_sel_eff`=`src_sel`, `pll_bypass`=`pll_bypass_req`, `pll_mult`=`pll_mult_req`.
- R2: The primary counter wraps once every 128 primary cycles, and every wrap restarts the secondary watchdog counter. A primary clock running at 1/32 of the secondary rate or faster is therefore never flagged.
- R3: A fault is flagged when 8192 secondary cycles pass with no primary wrap. After the primary stops, `clock_fail` rises within 8200 secondary cycles. A primary at 1/100 of the secondary rate is flagged.
- R4: After a detection the watchdog counter freezes. `fail_status` and `clock_fail` stay at 1 until a clear, even if the primary clock resumes.
- R5: While `fail_status`=1, `src_sel_eff` equals SEC_SRC (default 0) whatever `src_sel` holds, `pll_bypass`=1 and `pll_mult`=0.
- R6: A rising edge of `fail_clear_req` (held high for at least 3 secondary cycles) clears `fail_status` and `clock_fail` within 8 secondary cycles and zeroes both counters. With the primary stopped, the next detection follows 8190 to 8205 secondary cycles after the request rises.
- R7: While `mon_disable`=1 no detection occurs. After it returns to 0, a stopped primary is flagged again within 8300 secondary cycles. The monitor is enabled out of reset.
- R8: Once the fault is cleared, `src_sel_eff`, `pll_bypass` and `pll_mult` follow their inputs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pri_clk | input | 1 | Monitored primary clock |
| sec_clk | input | 1 | Always-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_disable | input | 1 | 1 suspends the check (asynchronous level) |
| fail_clear_req | input | 1 | Write-one-to-clear request, rising edge acts |
| src_sel | input | SRC_W | Normal oscillator source select |
| pll_bypass_req | input | 1 | Normal PLL bypass request |
| pll_mult_req | input | MULT_W | Normal PLL integer multiplier |
| fail_status | output | 1 | Sticky missing-clock status |
| clock_fail | output | 1 | Clock-fail level for trip and NMI |
| src_sel_eff | output | SRC_W | Effective source select |
| pll_bypass | output | 1 | Effective PLL bypass |
| pll_mult | output | MULT_W | Effective PLL multiplier |

## Verification
The assertions check the following on every cycle. A primary wrap flips the crossing toggle. The watchdog counter sets the fault when it runs out. The fault is sticky and the counter stays frozen while it is latched. A clear empties both the status and the counter. A disabled monitor holds its counter at zero. Only the bench scenarios can show the end-to-end timing across the two clock domains. These cover detection latency after a real stop, the margin between the 1/32 and 1/100 primary rates, and the override and release of the pass-through controls as seen at the ports.

// File: rtl/clm_pkg.sv
package clm_pkg;
  typedef struct packed {
    logic clr;   // one-cycle clear pulse in the secondary domain
    logic dis;   // synchronized disable level
  } clm_ctl_t;
endpackage

// File: rtl/clm_rst_sync.sv
module clm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], 1'b1};
  end
  assign srst_n = chain[STAGES-1];
endmodule

// File: rtl/clm_pri_count.sv
module clm_pri_count #(
  parameter int PRI_W = 7
) (
  input  logic pri_clk,
  input  logic prst_n,
  output logic wrap_tog
);
  localparam logic [PRI_W-1:0] CNT_MAX = '1;
  logic [PRI_W-1:0] cnt;

  always_ff @(posedge pri_clk or negedge prst_n) begin
    if (!prst_n) begin
      cnt      <= '0;
      wrap_tog <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      if (cnt == CNT_MAX) wrap_tog <= ~wrap_tog;
    end
  end

  // R2: every wrap of the primary counter is announced by a toggle
  a_r2_wrap_toggles: assert property (@(posedge pri_clk) disable iff (!prst_n)
    (cnt == CNT_MAX) |=> (wrap_tog != $past(wrap_tog)));
endmodule

// File: rtl/clm_toggle_sync.sv
module clm_toggle_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tog_in,
  output logic pulse
);
  logic [STAGES:0] chain;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], tog_in};
  end
  assign pulse = chain[STAGES] ^ chain[STAGES-1];
endmodule

// File: rtl/clm_ctrl_sync.sv
module clm_ctrl_sync #(
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_async,
  input  logic            dis_async,
  output clm_pkg::clm_ctl_t ctl
);
  localparam int NBITS = 2;
  logic [NBITS-1:0] raw;
  logic [NBITS-1:0] synced;
  logic             clr_prev;
  logic             clr_pulse;

  assign raw = {dis_async, clr_async};

  for (genvar b = 0; b < NBITS; b++) begin : g_bit
    logic [STAGES-1:0] ff;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= '0;
      else        ff <= {ff[STAGES-2:0], raw[b]};
    end
    assign synced[b] = ff[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_prev  <= 1'b0;
      clr_pulse <= 1'b0;
    end else begin
      clr_prev  <= synced[0];
      clr_pulse <= synced[0] & ~clr_prev;
    end
  end

  assign ctl.clr = clr_pulse;
  assign ctl.dis = synced[1];

  // R6: a clear request yields isolated one-cycle pulses
  a_r6_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> !clr_pulse);
endmodule

// File: rtl/clm_sec_detect.sv
module clm_sec_detect #(
  parameter int SEC_W = 13
) (
  input  logic              sec_clk,
  input  logic              rst_n,
  input  logic              restart,
  input  clm_pkg::clm_ctl_t ctl,
  output logic              fault,
  output logic              fail_lvl
);
  localparam logic [SEC_W-1:0] CNT_MAX = '1;
  logic [SEC_W-1:0] cnt;

  always_ff @(posedge sec_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      fault    <= 1'b0;
      fail_lvl <= 1'b0;
    end else if (ctl.clr) begin
      cnt      <= '0;
      fault    <= 1'b0;
      fail_lvl <= 1'b0;
    end else if (fault) begin
      cnt <= cnt;                       // frozen while latched
    end else if (ctl.dis || restart) begin
      cnt <= '0;
    end else if (cnt == CNT_MAX) begin
      fault    <= 1'b1;
      fail_lvl <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r3_run_out_sets: assert property (@(posedge sec_clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !fault && !ctl.clr && !ctl.dis && !restart) |=> (fault && fail_lvl));
  a_r4_sticky: assert property (@(posedge sec_clk) disable iff (!rst_n)
    (fault && !ctl.clr) |=> fault);
  a_r4_frozen: assert property (@(posedge sec_clk) disable iff (!rst_n)
    (fault && !ctl.clr) |=> $stable(cnt));
  a_r6_clear_empties: assert property (@(posedge sec_clk) disable iff (!rst_n)
    ctl.clr |=> (!fault && !fail_lvl && cnt == '0));
  a_r7_disabled_idle: assert property (@(posedge sec_clk) disable iff (!rst_n)
    (ctl.dis && !fault) |=> (cnt == '0 && !fault));
endmodule

// File: rtl/clk_loss_monitor.sv
module clk_loss_monitor #(
  parameter int                PRI_W   = 7,
  parameter int                SEC_W   = 13,
  parameter int                SRC_W   = 2,
  parameter int                MULT_W  = 7,
  parameter int                SYNC_N  = 2,
  parameter logic [SRC_W-1:0]  SEC_SRC = '0
) (
  input  logic              pri_clk,
  input  logic              sec_clk,
  input  logic              rst_n,
  input  logic              mon_disable,
  input  logic              fail_clear_req,
  input  logic [SRC_W-1:0]  src_sel,
  input  logic              pll_bypass_req,
  input  logic [MULT_W-1:0] pll_mult_req,
  output logic              fail_status,
  output logic              clock_fail,
  output logic [SRC_W-1:0]  src_sel_eff,
  output logic              pll_bypass,
  output logic [MULT_W-1:0] pll_mult
);
  clm_pkg::clm_ctl_t ctl;
  logic pri_arst_n;
  logic pri_rst_n;
  logic wrap_tog;
  logic restart;

  clm_ctrl_sync #(.STAGES(SYNC_N)) u_ctrl (
    .clk(sec_clk), .rst_n(rst_n),
    .clr_async(fail_clear_req), .dis_async(mon_disable), .ctl(ctl)
  );

  // clear reaches the primary counter asynchronously, so it works with no primary edges
  assign pri_arst_n = rst_n & ~ctl.clr;

  clm_rst_sync #(.STAGES(SYNC_N)) u_pri_rst (
    .clk(pri_clk), .arst_n(pri_arst_n), .srst_n(pri_rst_n)
  );

  clm_pri_count #(.PRI_W(PRI_W)) u_pri (
    .pri_clk(pri_clk), .prst_n(pri_rst_n), .wrap_tog(wrap_tog)
  );

  clm_toggle_sync #(.STAGES(SYNC_N)) u_xing (
    .clk(sec_clk), .rst_n(rst_n), .tog_in(wrap_tog), .pulse(restart)
  );

  clm_sec_detect #(.SEC_W(SEC_W)) u_det (
    .sec_clk(sec_clk), .rst_n(rst_n), .restart(restart), .ctl(ctl),
    .fault(fail_status), .fail_lvl(clock_fail)
  );

  always_comb begin
    if (fail_status) begin
      src_sel_eff = SEC_SRC;
      pll_bypass  = 1'b1;
      pll_mult    = '0;
    end else begin
      src_sel_eff = src_sel;
      pll_bypass  = pll_bypass_req;
      pll_mult    = pll_mult_req;
    end
  end
endmodule

// File: tb/test_clk_loss_monitor.sv
`timescale 1ns/1ps
module test_clk_loss_monitor;
  logic       pri_clk = 0, sec_clk = 0, rst_n = 0;
  logic       mon_disable = 0, fail_clear_req = 0, pll_bypass_req = 0;
  logic [1:0] src_sel = 2'd2;
  logic [6:0] pll_mult_req = 7'h1A;
  logic       fail_status, clock_fail, pll_bypass;
  logic [1:0] src_sel_eff;
  logic [6:0] pll_mult;

  bit pri_on = 0;
  int pri_half = 5;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 sec_clk = ~sec_clk;
  always begin
    if (pri_on) #(pri_half) pri_clk = ~pri_clk;
    else @(posedge pri_on);
  end

  clk_loss_monitor i_clk_loss_monitor (
    .pri_clk, .sec_clk, .rst_n, .mon_disable, .fail_clear_req, .src_sel,
    .pll_bypass_req, .pll_mult_req, .fail_status, .clock_fail,
    .src_sel_eff, .pll_bypass, .pll_mult
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge sec_clk);
  endtask

  task automatic check_pass(input string req);
    chk(src_sel_eff == src_sel, req, src_sel_eff, src_sel);
    chk(pll_bypass == pll_bypass_req, req, pll_bypass, pll_bypass_req);
    chk(pll_mult == pll_mult_req, req, pll_mult, pll_mult_req);
  endtask

  task automatic do_clear();
    @(negedge sec_clk) fail_clear_req = 1;
    wait_cyc(4);
    fail_clear_req = 0;
    wait_cyc(4);
  endtask

  // count secondary cycles until clock_fail, limited
  task automatic wait_fail(input int lim, output int n);
    n = 0;
    while (!clock_fail && n < lim) begin @(negedge sec_clk); n++; end
  endtask

  task automatic t_reset();   // R1
    chk(fail_status == 0, "R1 status", fail_status, 0);
    chk(clock_fail == 0, "R1 clock_fail", clock_fail, 0);
    check_pass("R1 pass-through");
  endtask

  task automatic t_fast_ok(); // R2
    pri_half = 5; pri_on = 1;
    wait_cyc(10000);
    chk(clock_fail == 0, "R2 fast primary", clock_fail, 0);
  endtask

  task automatic t_stop();    // R3, R5, R4
    int n;
    @(negedge sec_clk) pri_on = 0;
    wait_fail(9000, n);
    chk(n <= 8200 && n >= 7800, "R3 stop latency", n, 8192);
    chk(fail_status == 1, "R3 status set", fail_status, 1);
    src_sel = 2'd3; pll_mult_req = 7'h55; pll_bypass_req = 0;
    wait_cyc(2);
    chk(src_sel_eff == 2'd0, "R5 source forced", src_sel_eff, 0);
    chk(pll_bypass == 1, "R5 bypass forced", pll_bypass, 1);
    chk(pll_mult == 0, "R5 mult zero", pll_mult, 0);
    pri_on = 1;
    wait_cyc(2000);
    chk(fail_status == 1, "R4 sticky status", fail_status, 1);
    chk(clock_fail == 1, "R4 sticky fail", clock_fail, 1);
  endtask

  task automatic t_clear_redetect(); // R6, R8
    int n;
    bit cleared;
    @(negedge sec_clk) pri_on = 0;
    wait_cyc(20);
    @(negedge sec_clk) fail_clear_req = 1;
    n = 0; cleared = 0;
    repeat (8) begin @(negedge sec_clk); n++; if (n == 4) fail_clear_req = 0; end
    chk(fail_status == 0, "R6 status cleared", fail_status, 0);
    chk(clock_fail == 0, "R6 fail cleared", clock_fail, 0);
    check_pass("R8 released");
    while (!clock_fail && n < 9000) begin @(negedge sec_clk); n++; end
    chk(n >= 8190 && n <= 8205, "R6 redetect timing", n, 8196);
  endtask

  task automatic t_slow(input int half, input int wait_n, input bit expect_fail, input string req);
    pri_half = half; pri_on = 1;
    do_clear();
    wait_cyc(wait_n);
    chk(clock_fail == expect_fail, req, clock_fail, expect_fail);
  endtask

  task automatic t_disable(); // R7
    int n;
    pri_on = 0;
    mon_disable = 1;
    wait_cyc(5);
    do_clear();
    wait_cyc(12000);
    chk(clock_fail == 0, "R7 disabled no detect", clock_fail, 0);
    @(negedge sec_clk) mon_disable = 0;
    wait_fail(9000, n);
    chk(clock_fail == 1 && n <= 8300, "R7 re-enabled detect", n, 8195);
  endtask

  initial begin
    #(190000 * 4);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_cyc(5);
    rst_n = 1;
    wait_cyc(3);
    t_reset();
    t_fast_ok();
    t_stop();
    src_sel = 2'd2; pll_mult_req = 7'h1A; pll_bypass_req = 1;
    t_clear_redetect();
    t_slow(64, 20000, 0, "R2 primary at 1/32");
    t_slow(200, 12000, 1, "R3 primary at 1/100");
    t_disable();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule